// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a list of memory segments into the table of 8-byte descriptors that a bus-mastering DMA engine walks. Each segment arrives on a valid/ready stream as a 32-bit start address, a byte length and a flag marking the final beat. The block cuts every segment into chunks that never straddle a 64 KB address boundary. It writes one descriptor per chunk through a valid/ready table-write port, and it places the end-of-table marker on the last descriptor once the list is known to be complete.

A job begins with a one-cycle `start` pulse. The output format and the entry limit are captured at that pulse. Two length formats exist. In the byte format, a chunk of a full 64 KB is emitted as two 32 KB descriptors, because some DMA engines read a zero length field as nothing. In the dword format, lengths count 32-bit words minus one and no end marker is used. The job ends with a one-cycle `done` pulse. This pulse carries either the number of descriptors or an error code, so the caller can fall back to programmed I/O when the table is unusable.

Back-pressure rules are as follows. `seg_ready` is high only while a job runs and no segment is being split, and a beat is taken on any edge where both `seg_valid` and `seg_ready` are high. `tbl_valid`, once raised, holds with stable `tbl_idx` and `tbl_data` until `tbl_ready` is seen high at a clock edge. While the table port is stalled, no new chunk is produced.

Top module: `prd_gen`

## Requirements
- R1: After reset, `seg_ready`, `tbl_valid` and `done` are low. `start` outside the idle state is ignored, and `cfg_alt` and `cfg_limit` are used only as captured at the accepted `start`.
- R2: Each written descriptor has the chunk address in `tbl_data[31:0]` and the length word in `tbl_data[63:32]`. `tbl_idx` starts at 0 and rises by one per written descriptor.
- R3: No descriptor crosses a 64 KB boundary. The chunk size is the smaller of the bytes left in the segment and 0x10000 minus the address's low 16 bits.
- R4: In byte format (`cfg_alt`=0), length word bits 15:0 hold the byte count. A 64 KB chunk becomes two descriptors: the chunk address with 0x8000, then that address plus 0x8000 with 0x8000.
- R5: In byte format, bit 31 of the length word is set on the final descriptor of a successful job and on no other descriptor.
- R6: In dword format (`cfg_alt`=1), the length word is (bytes/4 - 1) in bits 31:16 with bits 15:0 zero. A 64 KB chunk is a single descriptor with field 0x3FFF, and bit 31 is never set.
- R7: When a further descriptor is needed after `cfg_limit` descriptors (at most MAX_ENTRIES) have been produced, including the second half of a 64 KB split, the job ends with code 4. On any error, the most recently produced descriptor is not written.
- R8: A zero-length beat with `seg_last`=1 terminates the list. If no descriptor has been produced yet, the job ends with code 1; otherwise the job ends successfully.
- R9: A zero-length beat with `seg_last`=0 ends the job with code 2. An address or length that is odd in byte format, or not a multiple of 4 in dword format, ends the job with code 3.
- R10: While `tbl_valid` is high and `tbl_ready` low, `tbl_valid`, `tbl_idx` and `tbl_data` stay unchanged. `seg_ready` is low while a segment is still being split and outside a running job.
- R11: `done` is a single-cycle pulse. `done_code` is 0 on success with `done_count` equal to the number of descriptors written; on failure `done_err` is 1 and `done_count` is 0. These outputs hold until the next job ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (idle only) |
| cfg_alt | input | 1 | 1 selects dword length format |
| cfg_limit | input | 9 | Maximum descriptor count, clipped to MAX_ENTRIES |
| seg_valid | input | 1 | Segment beat valid |
| seg_ready | output | 1 | Segment beat accepted when high with valid |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | 24 | Segment length in bytes |
| seg_last | input | 1 | Final beat of the list |
| tbl_valid | output | 1 | Descriptor write valid |
| tbl_ready | input | 1 | Table port accepts the write |
| tbl_idx | output | 8 | Descriptor index |
| tbl_data | output | 64 | Descriptor: length word in bits 63:32, address in bits 31:0 |
| done | output | 1 | Job finished (one cycle) |
| done_err | output | 1 | Job failed |
| done_code | output | 3 | 0 ok, 1 empty, 2 zero length, 3 misaligned, 4 overflow |
| done_count | output | 9 | Descriptors in the table on success |

## Verification
On every cycle, the assertions check that each offered descriptor stays inside its 64 KB window in whichever length format is active. They also check the dword-format field layout, that the write index stays below the captured limit, that stalled writes stay frozen, and that `done` is a clean one-cycle pulse with a non-zero count on success. Only the bench scenarios can show the exact descriptor sequence, the placement of the end marker on the last entry alone, the 32 KB split, and which descriptors survive an overflow or a bad segment. They also show that mid-job changes to the configuration pins and stray start pulses leave the table unchanged.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [2:0] {
    PRD_OK    = 3'd0,
    PRD_EMPTY = 3'd1,
    PRD_ZERO  = 3'd2,
    PRD_ALIGN = 3'd3,
    PRD_OVF   = 3'd4
  } prd_err_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_DONE
  } prd_state_e;

  localparam logic [16:0] PRD_SPAN = 17'h10000;
  localparam logic [16:0] PRD_HALF = 17'h08000;
endpackage

// File: rtl/prd_chunker.sv
module prd_chunker
  import prd_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic [15:0]      addr_lo,
  input  logic [LEN_W-1:0] rem,
  input  logic             alt,
  output logic [16:0]      bytes
);
  logic [16:0] to_bound;
  logic [31:0] rem32;
  logic [16:0] raw;

  always_comb begin
    to_bound = PRD_SPAN - {1'b0, addr_lo};
    rem32    = 32'(rem);
    raw      = (rem32 < {15'd0, to_bound}) ? rem32[16:0] : to_bound;
    // a full window cannot be encoded in 16 bits: halve it in byte format
    bytes    = (!alt && raw == PRD_SPAN) ? PRD_HALF : raw;
  end
endmodule

// File: rtl/prd_encoder.sv
module prd_encoder (
  input  logic [16:0] bytes,
  input  logic        alt,
  input  logic        eot,
  output logic [31:0] word
);
  logic [14:0] dw_m1;

  always_comb begin
    dw_m1 = bytes[16:2] - 15'd1;
    if (alt) word = {1'b0, dw_m1, 16'h0000};
    else     word = {eot, 15'h0000, bytes[15:0]};
  end
endmodule

// File: rtl/prd_gen.sv
module prd_gen
  import prd_pkg::*;
#(
  parameter int LEN_W       = 24,
  parameter int MAX_ENTRIES = 256,
  localparam int IDX_W      = $clog2(MAX_ENTRIES),
  localparam int CNT_W      = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_alt,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_last,
  output logic             tbl_valid,
  input  logic             tbl_ready,
  output logic [IDX_W-1:0] tbl_idx,
  output logic [63:0]      tbl_data,
  output logic             done,
  output logic             done_err,
  output logic [2:0]       done_code,
  output logic [CNT_W-1:0] done_count
);
  localparam logic [CNT_W-1:0] LIM_MAX = CNT_W'(MAX_ENTRIES);

  prd_state_e       state_q;
  prd_err_e         code_q;
  logic             alt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] count_q;
  logic             have_q;
  logic             last_q;
  logic [31:0]      addr_q;
  logic [LEN_W-1:0] rem_q;
  logic             pend_q;
  logic [31:0]      pend_addr_q;
  logic [16:0]      pend_bytes_q;
  logic [IDX_W-1:0] pend_idx_q;

  logic [16:0] chunk;
  logic [31:0] len_word;
  logic        ovf;
  logic        out_stall;
  logic        misalign;
  logic        seg_fire;

  prd_chunker #(.LEN_W(LEN_W)) chunk_i (
    .addr_lo (addr_q[15:0]),
    .rem     (rem_q),
    .alt     (alt_q),
    .bytes   (chunk)
  );

  prd_encoder enc_i (
    .bytes (pend_bytes_q),
    .alt   (alt_q),
    .eot   (state_q == ST_FLUSH),
    .word  (len_word)
  );

  always_comb begin
    ovf       = (cnt_q == lim_q);
    out_stall = pend_q && !tbl_ready;
    seg_ready = (state_q == ST_RUN) && !have_q;
    seg_fire  = seg_ready && seg_valid;
    misalign  = alt_q ? |{seg_addr[1:0], seg_len[1:0]} : (seg_addr[0] | seg_len[0]);
    // the held entry is offered only when a successor will displace it, or at the end
    tbl_valid = pend_q && (((state_q == ST_RUN) && have_q && !ovf) || (state_q == ST_FLUSH));
    tbl_idx   = pend_idx_q;
    tbl_data  = {len_word, pend_addr_q};
    done      = (state_q == ST_DONE);
    done_err  = (code_q != PRD_OK);
    done_code = code_q;
    done_count = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      code_q       <= PRD_OK;
      alt_q        <= 1'b0;
      lim_q        <= '0;
      cnt_q        <= '0;
      count_q      <= '0;
      have_q       <= 1'b0;
      last_q       <= 1'b0;
      addr_q       <= '0;
      rem_q        <= '0;
      pend_q       <= 1'b0;
      pend_addr_q  <= '0;
      pend_bytes_q <= '0;
      pend_idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            alt_q   <= cfg_alt;
            lim_q   <= (cfg_limit > LIM_MAX) ? LIM_MAX : cfg_limit;
            cnt_q   <= '0;
            have_q  <= 1'b0;
            pend_q  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (seg_fire) begin
            if (seg_len == '0) begin
              if (!seg_last) begin
                state_q <= ST_DONE;
                code_q  <= PRD_ZERO;
                count_q <= '0;
              end else if (cnt_q == '0) begin
                state_q <= ST_DONE;
                code_q  <= PRD_EMPTY;
                count_q <= '0;
              end else begin
                state_q <= ST_FLUSH;
              end
            end else if (misalign) begin
              state_q <= ST_DONE;
              code_q  <= PRD_ALIGN;
              count_q <= '0;
            end else begin
              have_q <= 1'b1;
              last_q <= seg_last;
              addr_q <= seg_addr;
              rem_q  <= seg_len;
            end
          end else if (have_q) begin
            if (ovf) begin
              state_q <= ST_DONE;
              code_q  <= PRD_OVF;
              count_q <= '0;
            end else if (!out_stall) begin
              pend_q       <= 1'b1;
              pend_addr_q  <= addr_q;
              pend_bytes_q <= chunk;
              pend_idx_q   <= cnt_q[IDX_W-1:0];
              cnt_q        <= cnt_q + 1'b1;
              addr_q       <= addr_q + 32'(chunk);
              rem_q        <= rem_q - LEN_W'(chunk);
              if (rem_q == LEN_W'(chunk)) begin
                have_q <= 1'b0;
                if (last_q) state_q <= ST_FLUSH;
              end
            end
          end
        end
        ST_FLUSH: begin
          if (tbl_ready) begin
            pend_q  <= 1'b0;
            state_q <= ST_DONE;
            code_q  <= PRD_OK;
            count_q <= cnt_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prd_gen_chk.sv
module prd_gen_chk #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tbl_valid,
  input logic             tbl_ready,
  input logic [IDX_W-1:0] tbl_idx,
  input logic [63:0]      tbl_data,
  input logic             seg_ready,
  input logic             done,
  input logic             done_err,
  input logic [CNT_W-1:0] done_count,
  input logic             alt_q,
  input logic [CNT_W-1:0] lim_q
);
  logic [16:0] byte_end;
  logic [14:0] dw_plus1;
  logic [16:0] dw_end;

  always_comb begin
    byte_end = {1'b0, tbl_data[15:0]} + {1'b0, tbl_data[47:32]};
    dw_plus1 = tbl_data[62:48] + 15'd1;
    dw_end   = {1'b0, tbl_data[15:0]} + {dw_plus1, 2'b00};
  end

  // R3
  byte_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_valid && !alt_q) |-> (tbl_data[47:32] != 16'h0 && byte_end <= 17'h10000));

  // R6
  dword_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_valid && alt_q) |-> (!tbl_data[63] && tbl_data[47:32] == 16'h0 && dw_end <= 17'h10000));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_valid && !tbl_ready) |=> (tbl_valid && $stable(tbl_data) && $stable(tbl_idx)));

  // R7
  idx_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_valid |-> ({1'b0, tbl_idx} < lim_q));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> (done_count != '0));

  // R10
  no_take_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !seg_ready);
endmodule

bind prd_gen prd_gen_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tbl_valid  (tbl_valid),
  .tbl_ready  (tbl_ready),
  .tbl_idx    (tbl_idx),
  .tbl_data   (tbl_data),
  .seg_ready  (seg_ready),
  .done       (done),
  .done_err   (done_err),
  .done_count (done_count),
  .alt_q      (alt_q),
  .lim_q      (lim_q)
);

// File: tb/prd_gen_tb_top.sv
`timescale 1ns/1ps
module prd_gen_tb_top;
  localparam int LEN_W = 24;
  localparam int IDX_W = 8;
  localparam int CNT_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             cfg_alt = 1'b0;
  logic [CNT_W-1:0] cfg_limit = '0;
  logic             seg_valid = 1'b0;
  logic             seg_ready;
  logic [31:0]      seg_addr = '0;
  logic [LEN_W-1:0] seg_len = '0;
  logic             seg_last = 1'b0;
  logic             tbl_valid;
  logic             tbl_ready = 1'b1;
  logic [IDX_W-1:0] tbl_idx;
  logic [63:0]      tbl_data;
  logic             done;
  logic             done_err;
  logic [2:0]       done_code;
  logic [CNT_W-1:0] done_count;

  prd_gen #(.LEN_W(LEN_W), .MAX_ENTRIES(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_alt(cfg_alt), .cfg_limit(cfg_limit),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_last(seg_last), .tbl_valid(tbl_valid), .tbl_ready(tbl_ready), .tbl_idx(tbl_idx),
    .tbl_data(tbl_data), .done(done), .done_err(done_err), .done_code(done_code),
    .done_count(done_count)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit job_done = 1'b0;
  bit stall_mode = 1'b0;
  int cyc = 0;
  string cur_req = "R2";

  logic [63:0] exp_q[$];
  int exp_idx;
  int exp_code;
  int exp_count;
  logic [31:0] s_addr[$];
  int s_len[$];
  bit s_last[$];

  bit prev_stall = 1'b0;
  logic [63:0] prev_data;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 tbl_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (running) begin
      if (prev_stall)
        chk(tbl_valid && tbl_data == prev_data, "R10", "stalled write changed", tbl_data, prev_data);
      prev_stall = tbl_valid && !tbl_ready;
      prev_data  = tbl_data;
      if (tbl_valid && tbl_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected write", tbl_data, 64'h0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(tbl_data == e, cur_req, "descriptor", tbl_data, e);
          chk(tbl_idx == IDX_W'(exp_idx), "R2", "index", 64'(tbl_idx), 64'(exp_idx));
          exp_idx++;
        end
      end
      if (done) begin
        job_done = 1'b1;
        chk(done_code == 3'(exp_code), cur_req, "done_code", 64'(done_code), 64'(exp_code));
        chk(done_err == (exp_code != 0), "R11", "done_err", 64'(done_err), 64'(exp_code != 0));
        chk(done_count == CNT_W'(exp_count), "R11", "done_count", 64'(done_count), 64'(exp_count));
      end
    end
  end

  task automatic add_seg(logic [31:0] a, int l, bit last);
    s_addr.push_back(a);
    s_len.push_back(l);
    s_last.push_back(last);
  endtask

  task automatic model(bit alt, int lim);
    int cnt;
    bit stop;
    longint a, r, b;
    logic [63:0] w;
    cnt = 0;
    stop = 1'b0;
    exp_q.delete();
    exp_code = 0;
    for (int i = 0; i < s_addr.size() && !stop; i++) begin
      a = longint'(s_addr[i]);
      r = longint'(s_len[i]);
      if (r == 0) begin
        if (s_last[i]) begin
          if (cnt == 0) exp_code = 1;
        end else exp_code = 2;
        stop = 1'b1;
      end else if (alt ? ((a % 4) != 0 || (r % 4) != 0) : ((a % 2) != 0 || (r % 2) != 0)) begin
        exp_code = 3;
        stop = 1'b1;
      end else begin
        while (r > 0 && !stop) begin
          b = 65536 - (a % 65536);
          if (r < b) b = r;
          if (!alt && b == 65536) b = 32768;
          if (cnt == lim) begin
            exp_code = 4;
            stop = 1'b1;
          end else begin
            w = alt ? 64'(((b / 4) - 1) * 65536) : 64'(b);
            exp_q.push_back({w[31:0], a[31:0]});
            cnt++;
            a = a + b;
            r = r - b;
          end
        end
        if (s_last[i]) stop = 1'b1;
      end
    end
    if (exp_code != 0) begin
      if (exp_q.size() > 0) void'(exp_q.pop_back());
      exp_count = 0;
    end else begin
      exp_count = cnt;
      if (!alt) exp_q[exp_q.size()-1][63] = 1'b1;
    end
  endtask

  task automatic run_job(string req, bit alt, int lim, bit stall, bit poke);
    model(alt, lim);
    cur_req = req;
    exp_idx = 0;
    job_done = 1'b0;
    stall_mode = stall;
    prev_stall = 1'b0;
    running = 1'b1;
    @(posedge clk); #1;
    cfg_alt = alt;
    cfg_limit = CNT_W'(lim);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      cfg_alt = !alt;
      cfg_limit = CNT_W'(1);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    for (int i = 0; i < s_addr.size(); i++) begin
      seg_valid = 1'b1;
      seg_addr = s_addr[i];
      seg_len = LEN_W'(s_len[i]);
      seg_last = s_last[i];
      do @(negedge clk); while (!seg_ready && !job_done);
      if (job_done) break;
      @(posedge clk); #1;
      seg_valid = 1'b0;
    end
    seg_valid = 1'b0;
    while (!job_done) @(negedge clk);
    chk(exp_q.size() == 0, req, "descriptors left unwritten", 64'(exp_q.size()), 64'h0);
    @(negedge clk);
    chk(!seg_ready && !tbl_valid, "R10", "quiet after job", 64'({seg_ready, tbl_valid}), 64'h0);
    running = 1'b0;
    s_addr.delete();
    s_len.delete();
    s_last.delete();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!seg_ready && !tbl_valid && !done, "R1", "reset outputs", 64'({seg_ready, tbl_valid, done}), 64'h0);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 a beat offered while idle is not taken
    seg_valid = 1'b1;
    seg_len = LEN_W'(16);
    @(negedge clk);
    chk(!seg_ready, "R1", "ready while idle", 64'(seg_ready), 64'h0);
    seg_valid = 1'b0;

    // R2 R5 single segment, byte format
    add_seg(32'h0000_1000, 'h200, 1'b1);
    run_job("R5", 1'b0, 256, 1'b0, 1'b0);

    // R3 R4 boundary split and 64 KB halving, with stalls
    add_seg(32'h0001_FF00, 'h300, 1'b0);
    add_seg(32'h0003_0000, 'h10000, 1'b1);
    run_job("R4", 1'b0, 256, 1'b1, 1'b0);

    // R3 long segment over several windows
    add_seg(32'h0005_4000, 'h2E000, 1'b1);
    run_job("R3", 1'b0, 256, 1'b0, 1'b0);

    // R6 dword format, full window single entry, stalls
    add_seg(32'h0002_F000, 'h11000, 1'b1);
    run_job("R6", 1'b1, 256, 1'b1, 1'b0);

    // R7 overflow on third entry
    add_seg(32'h0000_1000, 'h100, 1'b0);
    add_seg(32'h0000_2000, 'h100, 1'b0);
    add_seg(32'h0000_3000, 'h100, 1'b1);
    run_job("R7", 1'b0, 2, 1'b0, 1'b0);

    // R7 overflow caused by second half of a split
    add_seg(32'h0004_0000, 'h10000, 1'b1);
    run_job("R7", 1'b0, 1, 1'b0, 1'b0);

    // R7 exactly at the limit succeeds
    add_seg(32'h0000_1000, 'h100, 1'b0);
    add_seg(32'h0000_2000, 'h100, 1'b1);
    run_job("R7", 1'b0, 2, 1'b0, 1'b0);

    // R8 empty list
    add_seg(32'h0, 0, 1'b1);
    run_job("R8", 1'b0, 256, 1'b0, 1'b0);

    // R8 terminator after data ends normally
    add_seg(32'h0000_5000, 'h40, 1'b0);
    add_seg(32'h0000_6000, 'h80, 1'b0);
    add_seg(32'h0, 0, 1'b1);
    run_job("R8", 1'b0, 256, 1'b1, 1'b0);

    // R9 zero length mid list
    add_seg(32'h0000_1000, 'h100, 1'b0);
    add_seg(32'h0000_2000, 0, 1'b0);
    run_job("R9", 1'b0, 256, 1'b0, 1'b0);

    // R9 odd address in byte format
    add_seg(32'h0000_1001, 'h10, 1'b1);
    run_job("R9", 1'b0, 256, 1'b0, 1'b0);

    // R9 length not a dword multiple in dword format
    add_seg(32'h0000_1000, 'h102, 1'b1);
    run_job("R9", 1'b1, 256, 1'b0, 1'b0);

    // R1 R11 configuration changes and a start pulse during a job are ignored
    add_seg(32'h0000_FF00, 'h200, 1'b0);
    add_seg(32'h0001_0000, 'h400, 1'b1);
    run_job("R1", 1'b1, 4, 1'b0, 1'b1);

    finish_run();
  end
endmodule